// File: doc/BRIEF.md
# Run-Length Waveform Player

This block plays one digital output line from a list of run-length entries held in an internal buffer. Each 32-bit entry names a level and how many clock cycles that level lasts. Once started, the block reads the entries in address order and places every level change on an exact clock edge. Each edge of the waveform costs one entry, so asymmetric pulses, gate windows and single triggers are all cheap to describe. Every level is held for at least a fixed minimum number of cycles, and the time resolution is one clock cycle.

The buffer is filled through a simple write port while the player is idle or finished. A start pulse plays the list from entry 0. A stop pulse pauses playback with both the level and the remaining time frozen, and a later start resumes it. An abort pulse drops playback and returns the block to its reset condition. The player finishes on an entry of duration zero, or after the last buffer slot. Two status outputs, busy and done, show the playback state. A sticky error flag records writes that arrive during playback, which are refused.

Top module: `rle_wave_player`

## Requirements
- R1: After reset, wave_out, busy, done and wr_err are all 0.
- R2: An entry is 32 bits, with bit 31 as the level and bits 30:0 as the duration in clock cycles. A start sampled in idle or done at edge E plays the entries in order from address 0. Entry 0's level appears on wave_out at edge E+1, and each level is held for exactly its duration, with no gap cycle between entries.
- R3: An entry whose duration is 1 to MIN_HOLD-1 (default MIN_HOLD=5) holds its level for exactly MIN_HOLD cycles.
- R4: An entry with duration 0 ends playback at the edge where the previous level's hold ends. From then on done=1 and busy=0, and wave_out keeps the last level until the next start or abort.
- R5: If entry 0 has duration 0, done rises with no change on wave_out.
- R6: If no terminator appears, playback ends after the last buffer slot (address 2^ADDR_W-1), in the same way as a terminator.
- R7: A stop sampled during playback pauses it. wave_out and busy hold their values and the remaining hold time is frozen. A start sampled while paused resumes playback. The stop edge, each paused edge and the resume edge each lengthen the current level by one cycle.
- R8: An abort sampled in any state forces wave_out=0, busy=0 and done=0 on the next cycle. The next start plays from entry 0.
- R9: A write while busy=1 leaves the buffer unchanged and sets wr_err on the next cycle. wr_err stays set until a start begins a new playback, which clears it.
- R10: A start sampled while playback is running has no effect, and a stop sampled while idle or done has no effect.
- R11: A start sampled while done replays the whole list from entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | ADDR_W | Buffer write address |
| wr_data | input | 32 | Entry: bit 31 level, bits 30:0 duration |
| start | input | 1 | Begin playback, or resume from pause |
| stop | input | 1 | Pause playback |
| abort | input | 1 | Cancel playback and return to idle |
| wave_out | output | 1 | Generated waveform |
| busy | output | 1 | Playback in progress, including while paused |
| done | output | 1 | Playback finished |
| wr_err | output | 1 | Sticky flag for a refused write |

## Verification
The bench measures every run length on wave_out. This exposes a player that loses or adds a cycle at the seam between two entries, or that lets a short entry through without stretching it to the minimum hold. It plays a terminator as the first entry, a list with no terminator that runs off the end of the buffer, and a pause in the middle of a level. A wrong design would glitch the output, wrap around and play old entries, or let the frozen hold time run on during the pause. Writes and starts injected mid-run, followed by a replay from done and from an abort, catch a player whose buffer is corrupted, whose playback restarts, or that resumes from the wrong entry.

// File: rtl/rle_wave_pkg.sv
package rle_wave_pkg;

  localparam int ENTRY_W = 32;
  localparam int DUR_W   = 31;

  typedef struct packed {
    logic             level;
    logic [DUR_W-1:0] dur;
  } rle_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRIME = 3'd1,
    ST_RUN   = 3'd2,
    ST_PAUSE = 3'd3,
    ST_DONE  = 3'd4
  } play_state_e;

endpackage

// File: rtl/rle_rst_sync.sv
module rle_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end

endmodule

// File: rtl/rle_store.sv
module rle_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Write and read ports are independent; a read returns the old word
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/rle_sequencer.sv
module rle_sequencer
  import rle_wave_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int MIN_HOLD = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stop,
  input  logic               abort,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] rd_data,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               wave_out,
  output logic               busy,
  output logic               done,
  output logic               wr_err
);

  localparam int               PTR_W      = ADDR_W + 1;
  localparam logic [DUR_W-1:0] HOLD_FLOOR = DUR_W'(MIN_HOLD);

  play_state_e      state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [DUR_W-1:0] rem_q, rem_d;
  logic             lvl_q, lvl_d;
  logic             end_q, end_d;
  logic             err_q, err_d;
  logic             load;
  logic             seq_end;
  logic             active;
  logic             rem_en;
  rle_entry_t       entry;

  assign entry   = rle_entry_t'(rd_data);
  assign active  = (state_q == ST_PRIME) || (state_q == ST_RUN) || (state_q == ST_PAUSE);
  // rd_data holds the prefetched next entry; end_q marks "past last slot"
  assign seq_end = end_q || (entry.dur == '0);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    rem_d   = rem_q;
    lvl_d   = lvl_q;
    end_d   = end_q;
    err_d   = err_q;
    rd_en   = 1'b0;
    rd_addr = ptr_q[ADDR_W-1:0];
    load    = 1'b0;
    rem_en  = 1'b0;

    if (wr_en && active) begin
      err_d = 1'b1;
    end

    if (abort) begin
      state_d = ST_IDLE;
      lvl_d   = 1'b0;
      ptr_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state_d = ST_PRIME;
            err_d   = 1'b0;
            end_d   = 1'b0;
            rd_en   = 1'b1;
            rd_addr = '0;
            ptr_d   = PTR_W'(1);
          end
        end
        ST_PRIME: begin
          if (seq_end) state_d = ST_DONE;
          else         load    = 1'b1;
        end
        ST_RUN: begin
          if (stop) begin
            state_d = ST_PAUSE;
          end else if (rem_q != '0) begin
            rem_en = 1'b1;
            rem_d  = rem_q - DUR_W'(1);
          end else if (seq_end) begin
            state_d = ST_DONE;
          end else begin
            load = 1'b1;
          end
        end
        ST_PAUSE: begin
          if (start) state_d = ST_RUN;
        end
        default: state_d = ST_IDLE;
      endcase
    end

    if (load) begin
      state_d = ST_RUN;
      lvl_d   = entry.level;
      rem_en  = 1'b1;
      rem_d   = (entry.dur < HOLD_FLOOR) ? (HOLD_FLOOR - DUR_W'(1)) : (entry.dur - DUR_W'(1));
      end_d   = ptr_q[ADDR_W];
      if (!ptr_q[ADDR_W]) begin
        rd_en = 1'b1;
        ptr_d = ptr_q + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      rem_q   <= '0;
      lvl_q   <= 1'b0;
      end_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      lvl_q   <= lvl_d;
      end_q   <= end_d;
      err_q   <= err_d;
      if (rem_en) begin
        rem_q <= rem_d;
      end
    end
  end

  assign wave_out = lvl_q;
  assign busy     = active;
  assign done     = (state_q == ST_DONE);
  assign wr_err   = err_q;

endmodule

// File: rtl/rle_wave_player.sv
module rle_wave_player
  import rle_wave_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int MIN_HOLD = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               start,
  input  logic               stop,
  input  logic               abort,
  output logic               wave_out,
  output logic               busy,
  output logic               done,
  output logic               wr_err
);

  logic               rst_sync_n;
  logic               mem_we;
  logic               rd_en;
  logic [ADDR_W-1:0]  rd_addr;
  logic [ENTRY_W-1:0] rd_data;
  logic               busy_int;

  rle_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Writes during playback never reach the buffer
  assign mem_we = wr_en & ~busy_int;

  rle_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (ENTRY_W)
  ) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  rle_sequencer #(
    .ADDR_W   (ADDR_W),
    .MIN_HOLD (MIN_HOLD)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .stop     (stop),
    .abort    (abort),
    .wr_en    (wr_en),
    .rd_data  (rd_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .wave_out (wave_out),
    .busy     (busy_int),
    .done     (done),
    .wr_err   (wr_err)
  );

  assign busy = busy_int;

endmodule

// File: rtl/rle_wave_player_chk.sv
module rle_wave_player_chk #(
  parameter int MIN_HOLD = 5
) (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic abort,
  input logic wave_out,
  input logic busy,
  input logic done,
  input logic wr_err
);

  localparam int SEG_W = $clog2(MIN_HOLD + 1);

  logic             prev_out;
  logic             armed;
  logic [SEG_W-1:0] seg_len;
  logic             changed;

  assign changed = (wave_out != prev_out);

  // seg_len: cycles the previous level stayed visible (saturating)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_out <= 1'b0;
      armed    <= 1'b0;
      seg_len  <= '0;
    end else begin
      prev_out <= wave_out;
      armed    <= busy ? (changed | armed) : 1'b0;
      if (changed)                            seg_len <= SEG_W'(1);
      else if (seg_len != SEG_W'(MIN_HOLD))   seg_len <= seg_len + SEG_W'(1);
    end
  end

  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && armed && changed) |-> (seg_len == SEG_W'(MIN_HOLD))); // R3

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4

  AST_DONE_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !abort) |=> $stable(wave_out)); // R4

  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done && !wave_out)); // R8

  AST_BUSY_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> wr_err); // R9

endmodule

bind rle_wave_player rle_wave_player_chk #(.MIN_HOLD(MIN_HOLD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .abort    (abort),
  .wave_out (wave_out),
  .busy     (busy),
  .done     (done),
  .wr_err   (wr_err)
);

// File: tb/rle_wave_player_bench.sv
module rle_wave_player_bench;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int MINH  = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, start, stop, abort;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic          wave_out, busy, done, wr_err;

  always #2 clk = ~clk;

  rle_wave_player #(.ADDR_W(AW), .MIN_HOLD(MINH)) u_rle_wave_player (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .stop(stop), .abort(abort),
    .wave_out(wave_out), .busy(busy), .done(done), .wr_err(wr_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  bit cmp_on   = 0;
  bit rec_on   = 0;
  bit rec_q[$];
  bit seq_lvl[$];
  int seq_dur[$];

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // states: 0 idle, 1 prime, 2 run, 3 pause, 4 done
  logic [31:0] m_mem [DEPTH];
  int m_st = 0, m_ptr = 0, m_rem = 0;
  bit m_out = 0, m_err = 0;

  task automatic m_fetch();
    int d;
    if (m_ptr >= DEPTH || m_mem[m_ptr][30:0] == 0) begin
      m_st = 4;
    end else begin
      d     = int'(m_mem[m_ptr][30:0]);
      m_out = m_mem[m_ptr][31];
      m_rem = ((d < MINH) ? MINH : d) - 1;
      m_ptr++;
      m_st  = 2;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_rem = 0; m_out = 0; m_err = 0;
    end else begin
      if (wr_en) begin
        if (m_st >= 1 && m_st <= 3) m_err = 1;
        else m_mem[wr_addr] = wr_data;
      end
      if (abort) begin
        m_st = 0; m_out = 0; m_ptr = 0;
      end else begin
        case (m_st)
          0, 4: if (start) begin m_st = 1; m_err = 0; m_ptr = 0; end
          1: m_fetch();
          2: begin
            if (stop) m_st = 3;
            else if (m_rem > 0) m_rem--;
            else m_fetch();
          end
          3: if (start) m_st = 2;
          default: m_st = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 cycle wave_out", wave_out, m_out);
      chk("R4 cycle done", done, (m_st == 4));
      chk("R7 cycle busy", busy, (m_st >= 1 && m_st <= 3));
      chk("R9 cycle wr_err", wr_err, m_err);
    end
    if (rec_on && busy) rec_q.push_back(wave_out);
  end

  // ---------------- stimulus helpers ----------------
  task automatic write_entry(int addr, bit lvl, int dur);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(addr); wr_data = {lvl, 31'(dur)};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load_seq();
    for (int i = 0; i < seq_dur.size(); i++) write_entry(i, seq_lvl[i], seq_dur[i]);
    if (seq_dur.size() < DEPTH) write_entry(seq_dur.size(), 0, 0);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 5000; i++) begin
      if (done || !busy) break;
      @(negedge clk);
    end
  endtask

  task automatic play_record();
    rec_q.delete();
    rec_on = 1;
    pulse(start);
    wait_end();
    rec_on = 0;
    if (rec_q.size() > 0) void'(rec_q.pop_front());
  endtask

  task automatic compare_runs(string tag);
    bit r_l[$]; int r_n[$]; bit e_l[$]; int e_n[$];
    for (int i = 0; i < rec_q.size(); i++) begin
      if (r_n.size() > 0 && r_l[r_l.size()-1] == rec_q[i]) r_n[r_n.size()-1] = r_n[r_n.size()-1] + 1;
      else begin r_l.push_back(rec_q[i]); r_n.push_back(1); end
    end
    for (int i = 0; i < seq_dur.size(); i++) begin
      int h = (seq_dur[i] < MINH) ? MINH : seq_dur[i];
      if (e_n.size() > 0 && e_l[e_l.size()-1] == seq_lvl[i]) e_n[e_n.size()-1] = e_n[e_n.size()-1] + h;
      else begin e_l.push_back(seq_lvl[i]); e_n.push_back(h); end
    end
    chk({tag, " run count"}, r_n.size(), e_n.size());
    for (int i = 0; i < e_n.size() && i < r_n.size(); i++) begin
      chk({tag, " run length"}, r_n[i], e_n[i]);
      chk({tag, " run level"}, r_l[i], e_l[i]);
    end
  endtask

  task automatic set_a();
    seq_lvl = '{1, 0, 1, 0};
    seq_dur = '{7, 5, 12, 6};
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  // ---------------- test sequence ----------------
  initial begin
    rst_n = 0; wr_en = 0; start = 0; stop = 0; abort = 0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 reset wave_out", wave_out, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset wr_err", wr_err, 0);
    cmp_on = 1;

    // R2 / R4: plain asymmetric sequence, level kept after terminator
    set_a(); load_seq();
    play_record();
    compare_runs("R2 seqA");
    repeat (3) @(negedge clk);
    chk("R4 done held", done, 1);
    chk("R4 busy low", busy, 0);
    chk("R4 level kept", wave_out, 0);

    // R2 latency: entry 0 level visible two negedges after start drive
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R2 prime keeps old level", wave_out, 0);
    @(negedge clk);
    chk("R2 first level on E+1", wave_out, 1);
    wait_end();

    // R3: short durations stretched to the minimum
    seq_lvl = '{1, 0, 1, 0};
    seq_dur = '{2, 1, 4, 9};
    load_seq();
    play_record();
    compare_runs("R3 short");

    // R5: ends high, then terminator as first entry
    seq_lvl = '{0, 1};
    seq_dur = '{5, 8};
    load_seq();
    play_record();
    compare_runs("R4 end high");
    write_entry(0, 0, 0);
    pulse(start);
    repeat (2) @(negedge clk);
    chk("R5 empty done", done, 1);
    chk("R5 level untouched", wave_out, 1);

    // R6: no terminator, run off the end of the buffer
    seq_lvl.delete(); seq_dur.delete();
    for (int i = 0; i < DEPTH; i++) begin
      seq_lvl.push_back(i[0]);
      seq_dur.push_back(MINH);
    end
    load_seq();
    play_record();
    compare_runs("R6 full buffer");
    chk("R6 done after last slot", done, 1);

    // R7: pause and resume
    seq_lvl = '{1, 0};
    seq_dur = '{20, 5};
    load_seq();
    rec_q.delete();
    rec_on = 1;
    pulse(start);
    repeat (6) @(negedge clk);
    stop = 1;
    @(negedge clk); stop = 0;
    repeat (4) @(negedge clk);
    chk("R7 paused level", wave_out, 1);
    chk("R7 paused busy", busy, 1);
    chk("R7 paused done", done, 0);
    start = 1;
    @(negedge clk); start = 0;
    wait_end();
    rec_on = 0;
    void'(rec_q.pop_front());
    seq_dur = '{26, 5};
    compare_runs("R7 paused run");

    // R8: abort mid-run, then full replay from entry 0
    set_a(); load_seq();
    pulse(start);
    repeat (10) @(negedge clk);
    abort = 1;
    @(negedge clk); abort = 0;
    chk("R8 abort wave_out", wave_out, 0);
    chk("R8 abort busy", busy, 0);
    chk("R8 abort done", done, 0);
    play_record();
    compare_runs("R8 replay");

    // R9 / R10: write and start while running; R11 replay from done
    rec_q.delete();
    rec_on = 1;
    pulse(start);
    repeat (4) @(negedge clk);
    write_entry(0, 0, 9);
    chk("R9 busy write flagged", wr_err, 1);
    pulse(start);
    wait_end();
    rec_on = 0;
    void'(rec_q.pop_front());
    compare_runs("R10 start ignored");
    chk("R9 flag sticky", wr_err, 1);
    play_record();
    compare_runs("R11 replay from done");
    chk("R9 flag cleared by start", wr_err, 0);

    // R10: stop while done has no effect
    pulse(stop);
    repeat (2) @(negedge clk);
    chk("R10 idle stop done", done, 1);
    chk("R10 idle stop busy", busy, 0);
    play_record();
    compare_runs("R10 after idle stop");

    repeat (3) @(negedge clk);
    report();
  end

endmodule